// File: doc/BRIEF.md
# Floating-Point Exception Trap Prioritizer

This block sits right after the rounding stage of a floating-point arithmetic pipeline. It gets two versions of the rounded result. One version is computed as if the exponent range had no bound; the other is rounded into the real bounded range. From these, the sign, the rounding mode and the trap controls, the block picks the value that is delivered. It also works out which sticky status flags this operation raises, and whether an interruption is taken. When one is taken, it sets the interruption code bits for overflow, underflow, inexact and round-up.

The decision has a fixed order. A result that was already known to be zero or infinity skips the range checks. Overflow is checked next, then tininess, then plain inexactness. When the overflow or underflow trap is enabled, the unbounded exponent is wrapped modulo 2^17, or modulo 2^8 for packed operations. When they are disabled, the result is replaced by a saturated value, a flushed zero, or the bounded-range result. Inputs are taken when `in_valid` is high. Every output comes from a register and appears one cycle later, together with `out_valid`.

Top module: `fp_trap_prio`

## Requirements
- R1: Every output is registered. A result taken while `in_valid` is high appears on the next cycle with `out_valid` high. When `out_valid` is low, every output is 0. After reset, every output is 0.
- R2: When `special_res` is 1, the bounded result (`bnd_exp`, `bnd_sig`) is delivered. No status flag is raised and no trap is taken, even when the unbounded exponent is out of range.
- R3: Overflow means the unbounded exponent is above EMAX. With the overflow trap enabled, the block does the following:
  - delivers the exponent modulo 2^17 and `unb_sig`;
  - raises `sts_ovf` and sets `sts_inx` equal to `unb_inexact`;
  - sets `intr_ovf` to 1, `intr_inx` to `unb_inexact` and `intr_up` to `unb_roundup`;
  - pulses `trap_pulse`.
- R4: On overflow with the trap disabled, both `sts_ovf` and `sts_inx` are raised. The delivered value is infinity (exponent all ones, significand MSB only) in these cases: `rnd_mode` is 0 (nearest); `rnd_mode` is 2 (toward +inf) with a positive sign; `rnd_mode` is 1 (toward -inf) with a negative sign. In every other case it is the largest finite value (exponent all ones minus 1, significand all ones). If the inexact trap is enabled, a trap is taken with `intr_inx`=1, and `intr_up` is 1 only when infinity was delivered.
- R5: Tiny means the unbounded exponent is below EMIN. With the underflow trap enabled, every tiny result does the following, whether it is exact or not and even when `ftz` is 1:
  - delivers the exponent modulo 2^17 and `unb_sig`;
  - raises `sts_unf` and sets `sts_inx` equal to `unb_inexact`;
  - sets `intr_unf` to 1, `intr_inx` to `unb_inexact` and `intr_up` to `unb_roundup`;
  - pulses `trap_pulse`.
- R6: A tiny result with the underflow trap disabled and `ftz` at 0 delivers the bounded result. If `bnd_inexact` is 1, it raises `sts_unf` and `sts_inx`; if `bnd_inexact` is 0, it raises no flag.
- R7: A tiny result with the underflow trap disabled and `ftz` at 1 delivers a zero (exponent 0, significand 0) that keeps the sign. It raises `sts_unf` and `sts_inx`. If the inexact trap is enabled, it traps with `intr_up` at 0.
- R8: An in-range result delivers the unbounded exponent and `unb_sig`. If `unb_inexact` is 1, it raises `sts_inx`, and with the inexact trap enabled it traps with `intr_inx`=1 and `intr_up`=`unb_roundup`.
- R9: When `packed_mode` is 1, the wrapped exponent of a trapped overflow or underflow is the unbounded exponent modulo 2^8, zero-extended.
- R10: `trap_pulse` is high only together with at least one of `intr_ovf`, `intr_unf`, `intr_inx`. When there is no trap, every interruption code bit is 0. `intr_ovf` and `intr_unf` never both rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inputs are taken this cycle |
| unb_exp | input | EXP_W+2 | Signed biased exponent, unbounded-range rounding |
| unb_sig | input | SIG_W | Significand, unbounded-range rounding |
| unb_inexact | input | 1 | Unbounded rounding was inexact |
| unb_roundup | input | 1 | Unbounded rounding incremented the significand |
| bnd_exp | input | EXP_W | Exponent from bounded-range rounding or precomputed value |
| bnd_sig | input | SIG_W | Significand from bounded-range rounding or precomputed value |
| bnd_inexact | input | 1 | Bounded rounding was inexact |
| bnd_roundup | input | 1 | Bounded rounding incremented the significand |
| special_res | input | 1 | Result is a precomputed zero or infinity |
| sign | input | 1 | Result sign (1 = negative) |
| rnd_mode | input | 2 | 0 nearest, 1 toward -inf, 2 toward +inf, 3 toward zero |
| en_ovf | input | 1 | Overflow trap enable |
| en_unf | input | 1 | Underflow trap enable |
| en_inx | input | 1 | Inexact trap enable |
| ftz | input | 1 | Flush tiny results to zero |
| packed_mode | input | 1 | Packed operation: wrap modulo 2^8 |
| out_valid | output | 1 | Outputs carry a result |
| res_sign | output | 1 | Delivered sign |
| res_exp | output | EXP_W | Delivered exponent |
| res_sig | output | SIG_W | Delivered significand |
| sts_ovf | output | 1 | Overflow status flag update |
| sts_unf | output | 1 | Underflow status flag update |
| sts_inx | output | 1 | Inexact status flag update |
| intr_ovf | output | 1 | Interruption code: overflow |
| intr_unf | output | 1 | Interruption code: underflow |
| intr_inx | output | 1 | Interruption code: inexact |
| intr_up | output | 1 | Interruption code: delivered magnitude above exact |
| trap_pulse | output | 1 | Trap taken, one cycle per result |

## Verification
Two cases are provoked in the same result. In the first, a saturating overflow (trap disabled) is combined with an enabled inexact trap. The bench checks that the overflow and inexact flags rise together with an inexact-only trap, and that `intr_up` tracks whether infinity or the largest finite value was chosen. In the second, a tiny result arrives while the underflow trap and flush-to-zero are both armed. The bench checks that the wrapped, trapped result wins over the flushed zero. Each case is judged by comparing the full output word with a value worked out from the requirements.

// File: rtl/fptp_pkg.sv
package fptp_pkg;
    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_DOWN = 2'd1,
        RND_UP   = 2'd2,
        RND_ZERO = 2'd3
    } rnd_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } sts_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
        logic up;
    } intr_t;
endpackage

// File: rtl/fptp_classify.sv
module fptp_classify #(
    parameter int UEXP_W = 19,
    parameter int EMIN   = 1,
    parameter int EMAX   = 131070
) (
    input  logic signed [UEXP_W-1:0] exp_i,
    output logic                     ovf_o,
    output logic                     tiny_o
);
    localparam logic signed [UEXP_W-1:0] EMIN_S = UEXP_W'(EMIN);
    localparam logic signed [UEXP_W-1:0] EMAX_S = UEXP_W'(EMAX);

    // rounded exponent decides range; significand is normalized
    assign ovf_o  = exp_i > EMAX_S;
    assign tiny_o = exp_i < EMIN_S;
endmodule

// File: rtl/fptp_sat_select.sv
module fptp_sat_select
    import fptp_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    output logic       use_inf_o
);
    rnd_e mode;
    assign mode = rnd_e'(mode_i);

    always_comb begin
        unique case (mode)
            RND_NEAR: use_inf_o = 1'b1;
            RND_UP:   use_inf_o = !sign_i;
            RND_DOWN: use_inf_o = sign_i;
            default:  use_inf_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fptp_wrap.sv
module fptp_wrap #(
    parameter int UEXP_W = 19,
    parameter int EXP_W  = 17,
    parameter int PEXP_W = 8
) (
    input  logic signed [UEXP_W-1:0] exp_i,
    input  logic                     packed_i,
    output logic [EXP_W-1:0]         exp_o
);
    logic [EXP_W-1:0] wide_wrap;
    logic [EXP_W-1:0] narrow_wrap;

    assign wide_wrap   = exp_i[EXP_W-1:0];
    assign narrow_wrap = EXP_W'(exp_i[PEXP_W-1:0]);
    assign exp_o       = packed_i ? narrow_wrap : wide_wrap;
endmodule

// File: rtl/fp_trap_prio.sv
module fp_trap_prio
    import fptp_pkg::*;
#(
    parameter int EXP_W  = 17,
    parameter int PEXP_W = 8,
    parameter int SIG_W  = 64,
    parameter int EMIN   = 1,
    parameter int EMAX   = (1 << EXP_W) - 2,
    localparam int UEXP_W = EXP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [UEXP_W-1:0] unb_exp,
    input  logic [SIG_W-1:0]         unb_sig,
    input  logic                     unb_inexact,
    input  logic                     unb_roundup,
    input  logic [EXP_W-1:0]         bnd_exp,
    input  logic [SIG_W-1:0]         bnd_sig,
    input  logic                     bnd_inexact,
    input  logic                     bnd_roundup,
    input  logic                     special_res,
    input  logic                     sign,
    input  logic [1:0]               rnd_mode,
    input  logic                     en_ovf,
    input  logic                     en_unf,
    input  logic                     en_inx,
    input  logic                     ftz,
    input  logic                     packed_mode,
    output logic                     out_valid,
    output logic                     res_sign,
    output logic [EXP_W-1:0]         res_exp,
    output logic [SIG_W-1:0]         res_sig,
    output logic                     sts_ovf,
    output logic                     sts_unf,
    output logic                     sts_inx,
    output logic                     intr_ovf,
    output logic                     intr_unf,
    output logic                     intr_inx,
    output logic                     intr_up,
    output logic                     trap_pulse
);
    localparam logic [EXP_W-1:0] INF_EXP = EXP_W'(EMAX + 1);
    localparam logic [EXP_W-1:0] MAX_EXP = EXP_W'(EMAX);
    localparam logic [SIG_W-1:0] INF_SIG = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic [SIG_W-1:0] MAX_SIG = {SIG_W{1'b1}};

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        sts_t             sts;
        intr_t            intr;
        logic             trap;
    } out_t;

    out_t st_d, st_q;

    logic             is_ovf, is_tiny, use_inf;
    logic [EXP_W-1:0] wrap_exp;

    fptp_classify #(.UEXP_W(UEXP_W), .EMIN(EMIN), .EMAX(EMAX)) u_class (
        .exp_i (unb_exp),
        .ovf_o (is_ovf),
        .tiny_o(is_tiny)
    );

    fptp_sat_select u_sat (
        .mode_i   (rnd_mode),
        .sign_i   (sign),
        .use_inf_o(use_inf)
    );

    fptp_wrap #(.UEXP_W(UEXP_W), .EXP_W(EXP_W), .PEXP_W(PEXP_W)) u_wrap (
        .exp_i   (unb_exp),
        .packed_i(packed_mode),
        .exp_o   (wrap_exp)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.sign = sign;
            if (special_res) begin
                st_d.exp = bnd_exp;
                st_d.sig = bnd_sig;
            end else if (is_ovf) begin
                if (en_ovf) begin
                    st_d.exp  = wrap_exp;
                    st_d.sig  = unb_sig;
                    st_d.sts  = '{ovf: 1'b1, unf: 1'b0, inx: unb_inexact};
                    st_d.intr = '{ovf: 1'b1, unf: 1'b0, inx: unb_inexact, up: unb_roundup};
                    st_d.trap = 1'b1;
                end else begin
                    st_d.exp = use_inf ? INF_EXP : MAX_EXP;
                    st_d.sig = use_inf ? INF_SIG : MAX_SIG;
                    st_d.sts = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
                    if (en_inx) begin
                        st_d.intr = '{ovf: 1'b0, unf: 1'b0, inx: 1'b1, up: use_inf};
                        st_d.trap = 1'b1;
                    end
                end
            end else if (is_tiny) begin
                if (en_unf) begin
                    st_d.exp  = wrap_exp;
                    st_d.sig  = unb_sig;
                    st_d.sts  = '{ovf: 1'b0, unf: 1'b1, inx: unb_inexact};
                    st_d.intr = '{ovf: 1'b0, unf: 1'b1, inx: unb_inexact, up: unb_roundup};
                    st_d.trap = 1'b1;
                end else if (ftz) begin
                    st_d.sts = '{ovf: 1'b0, unf: 1'b1, inx: 1'b1};
                    if (en_inx) begin
                        st_d.intr = '{ovf: 1'b0, unf: 1'b0, inx: 1'b1, up: 1'b0};
                        st_d.trap = 1'b1;
                    end
                end else begin
                    st_d.exp = bnd_exp;
                    st_d.sig = bnd_sig;
                    if (bnd_inexact) begin
                        st_d.sts = '{ovf: 1'b0, unf: 1'b1, inx: 1'b1};
                        if (en_inx) begin
                            st_d.intr = '{ovf: 1'b0, unf: 1'b0, inx: 1'b1, up: bnd_roundup};
                            st_d.trap = 1'b1;
                        end
                    end
                end
            end else begin
                st_d.exp = unb_exp[EXP_W-1:0];
                st_d.sig = unb_sig;
                if (unb_inexact) begin
                    st_d.sts.inx = 1'b1;
                    if (en_inx) begin
                        st_d.intr = '{ovf: 1'b0, unf: 1'b0, inx: 1'b1, up: unb_roundup};
                        st_d.trap = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign res_sign   = st_q.sign;
    assign res_exp    = st_q.exp;
    assign res_sig    = st_q.sig;
    assign sts_ovf    = st_q.sts.ovf;
    assign sts_unf    = st_q.sts.unf;
    assign sts_inx    = st_q.sts.inx;
    assign intr_ovf   = st_q.intr.ovf;
    assign intr_unf   = st_q.intr.unf;
    assign intr_inx   = st_q.intr.inx;
    assign intr_up    = st_q.intr.up;
    assign trap_pulse = st_q.trap;
endmodule

// File: rtl/fptp_checker.sv
module fptp_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic sts_ovf,
    input logic sts_unf,
    input logic sts_inx,
    input logic intr_ovf,
    input logic intr_unf,
    input logic intr_inx,
    input logic intr_up,
    input logic trap_pulse
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap_pulse && !sts_ovf && !sts_unf && !sts_inx));
    // R10
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (out_valid && (intr_ovf || intr_unf || intr_inx)));
    // R10
    quiet_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> !(intr_ovf || intr_unf || intr_inx || intr_up));
    // R10
    ou_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({intr_ovf, intr_unf}) <= 1);
    // R3
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ovf |-> (sts_ovf && !sts_unf));
    // R5
    unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_unf |-> (sts_unf && !sts_ovf));
endmodule

bind fp_trap_prio fptp_checker u_fptp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .sts_ovf   (sts_ovf),
    .sts_unf   (sts_unf),
    .sts_inx   (sts_inx),
    .intr_ovf  (intr_ovf),
    .intr_unf  (intr_unf),
    .intr_inx  (intr_inx),
    .intr_up   (intr_up),
    .trap_pulse(trap_pulse)
);

// File: tb/tb_fp_trap_prio.sv
`timescale 1ns/1ps
module tb_fp_trap_prio;
    localparam int EXP_W = 17;
    localparam int SIG_W = 64;
    localparam int OW    = 1 + EXP_W + SIG_W + 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0;
    logic signed [EXP_W+1:0] unb_exp = '0;
    logic [SIG_W-1:0] unb_sig = '0, bnd_sig = '0;
    logic [EXP_W-1:0] bnd_exp = '0;
    logic unb_inexact = 0, unb_roundup = 0, bnd_inexact = 0, bnd_roundup = 0;
    logic special_res = 0, sign = 0, en_ovf = 0, en_unf = 0, en_inx = 0, ftz = 0, packed_mode = 0;
    logic [1:0] rnd_mode = 2'd0;
    logic out_valid, res_sign, sts_ovf, sts_unf, sts_inx;
    logic intr_ovf, intr_unf, intr_inx, intr_up, trap_pulse;
    logic [EXP_W-1:0] res_exp;
    logic [SIG_W-1:0] res_sig;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    localparam logic [SIG_W-1:0] SA = 64'hC3A5_0000_1234_5679;
    localparam logic [SIG_W-1:0] SB = 64'h0000_0000_0ABC_DEF1;
    localparam logic [SIG_W-1:0] INF_S = 64'h8000_0000_0000_0000;
    localparam logic [SIG_W-1:0] MAX_S = 64'hFFFF_FFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    fp_trap_prio dut (.*);

    wire [OW-1:0] obs = {res_sign, res_exp, res_sig, sts_ovf, sts_unf, sts_inx,
                         intr_ovf, intr_unf, intr_inx, intr_up, trap_pulse};

    function automatic logic [OW-1:0] mk(input logic s, input logic [EXP_W-1:0] e,
        input logic [SIG_W-1:0] m, input logic [2:0] st, input logic [3:0] ic, input logic t);
        return {s, e, m, st, ic, t};
    endfunction

    task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        unb_exp = '0; unb_sig = '0; unb_inexact = 0; unb_roundup = 0;
        bnd_exp = '0; bnd_sig = '0; bnd_inexact = 0; bnd_roundup = 0;
        special_res = 0; sign = 0; rnd_mode = 2'd0;
        en_ovf = 0; en_unf = 0; en_inx = 0; ftz = 0; packed_mode = 0;
    endtask

    // inputs already set; pulse valid and stop at the negedge after the capturing edge
    task automatic fire();
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        n_chk++;
        if (out_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL R1: out_valid actual %b expected 1", out_valid);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset", obs, '0);
        chk("R1 reset valid", OW'(out_valid), '0);
    endtask

    task automatic t_normal();
        @(negedge clk); clear_in();
        unb_exp = 19'sd1000; unb_sig = SA; en_inx = 1;
        fire();
        chk("R8 exact", obs, mk(0, 17'd1000, SA, 3'b000, 4'b0000, 0));
        clear_in(); unb_exp = 19'sd2000; unb_sig = SB; unb_inexact = 1; sign = 1;
        fire();
        chk("R8 inexact untrapped", obs, mk(1, 17'd2000, SB, 3'b001, 4'b0000, 0));
        clear_in(); unb_exp = 19'sd77; unb_sig = SA; unb_inexact = 1; unb_roundup = 1; en_inx = 1;
        fire();
        chk("R8 inexact trapped", obs, mk(0, 17'd77, SA, 3'b001, 4'b0011, 1));
        @(negedge clk);
        chk("R1 idle after result", {obs[OW-1:1], out_valid}, '0);
    endtask

    task automatic t_ovf_enabled();
        @(negedge clk); clear_in();
        unb_exp = 19'sd131075; unb_sig = SA; unb_inexact = 1; unb_roundup = 1; en_ovf = 1;
        fire();
        chk("R3 wrap", obs, mk(0, 17'd3, SA, 3'b101, 4'b1011, 1));
    endtask

    task automatic t_ovf_disabled();
        @(negedge clk); clear_in();
        unb_exp = 19'sd140000; unb_sig = SA; rnd_mode = 2'd0;
        fire();
        chk("R4 nearest inf", obs, mk(0, 17'h1FFFF, INF_S, 3'b101, 4'b0000, 0));
        clear_in(); unb_exp = 19'sd140000; sign = 1; rnd_mode = 2'd3; en_inx = 1;
        fire();
        chk("R4 zero-dir max with inexact trap", obs, mk(1, 17'h1FFFE, MAX_S, 3'b101, 4'b0010, 1));
        clear_in(); unb_exp = 19'sd131071; sign = 1; rnd_mode = 2'd1; en_inx = 1;
        fire();
        chk("R4 down negative inf", obs, mk(1, 17'h1FFFF, INF_S, 3'b101, 4'b0011, 1));
        clear_in(); unb_exp = 19'sd131071; sign = 1; rnd_mode = 2'd2;
        fire();
        chk("R4 up negative max", obs, mk(1, 17'h1FFFE, MAX_S, 3'b101, 4'b0000, 0));
    endtask

    task automatic t_unf_enabled();
        @(negedge clk); clear_in();
        unb_exp = -19'sd3; unb_sig = SB; en_unf = 1; ftz = 1;
        fire();
        chk("R5 exact tiny wraps over ftz", obs, mk(0, 17'h1FFFD, SB, 3'b010, 4'b0100, 1));
        clear_in(); unb_exp = -19'sd300; unb_sig = SA; unb_inexact = 1; unb_roundup = 1; en_unf = 1;
        fire();
        chk("R5 inexact tiny", obs, mk(0, 17'h1FED4, SA, 3'b011, 4'b0111, 1));
        packed_mode = 1;
        fire();
        chk("R9 packed wrap", obs, mk(0, 17'h000D4, SA, 3'b011, 4'b0111, 1));
    endtask

    task automatic t_unf_disabled();
        @(negedge clk); clear_in();
        unb_exp = 19'sd0; unb_sig = SA; unb_inexact = 1;
        bnd_exp = 17'd0; bnd_sig = SB; bnd_inexact = 1; bnd_roundup = 1;
        fire();
        chk("R6 tiny inexact", obs, mk(0, 17'd0, SB, 3'b011, 4'b0000, 0));
        bnd_inexact = 0; bnd_roundup = 0; unb_inexact = 0; en_inx = 1;
        fire();
        chk("R6 tiny exact", obs, mk(0, 17'd0, SB, 3'b000, 4'b0000, 0));
    endtask

    task automatic t_ftz();
        @(negedge clk); clear_in();
        unb_exp = -19'sd10; unb_sig = SA; unb_roundup = 1; sign = 1; ftz = 1; en_inx = 1;
        bnd_sig = SB;
        fire();
        chk("R7 flush", obs, mk(1, 17'd0, 64'd0, 3'b011, 4'b0010, 1));
    endtask

    task automatic t_special();
        @(negedge clk); clear_in();
        unb_exp = 19'sd150000; unb_inexact = 1; en_ovf = 1; en_inx = 1; special_res = 1;
        bnd_exp = 17'h1FFFF; bnd_sig = INF_S; sign = 1;
        fire();
        chk("R2 special bypass", obs, mk(1, 17'h1FFFF, INF_S, 3'b000, 4'b0000, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_normal();
        t_ovf_enabled();
        t_ovf_disabled();
        t_unf_enabled();
        t_unf_disabled();
        t_ftz();
        t_special();
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule